// File: doc/BRIEF.md
# Primary/Secondary Error Status Logger

This block records error events in three 64-bit status registers, one for each error category: uncorrectable, correctable and other. An event names a category and a primary bit index in the lower half of the register. The first occurrence of an enabled error sets the primary bit. A repeat, while the primary bit is still set, sets a secondary bit 32 positions higher. Further repeats are dropped without trace. Each category has a 64-bit enable register. An event counts only when the enable bit at its primary index is 1.

Software reaches the block through a simple strobe port. A write to a status address clears the bits that are 1 in the data. A write to the paired alias address sets them. A read returns the addressed register one cycle later.

When an uncorrectable event logs the first primary bit of that register and carries a receive header, the block captures the 16-byte header into two 64-bit header words. Header byte 0 lands at the top of the first word.

The event input is a valid/ready stream. The block applies no back-pressure: ready is high in every cycle outside reset, and an event counts when valid and ready are both high.

Top module: `errlog_top`

## Requirements
- R1: An event changes no status bit when the enable bit of its category at its primary index is 0.
- R2: For an enabled event with primary index p (0..31), the block sets bit p if it is clear. If bit p is set and bit p+32 is clear, it sets bit p+32. If both are set, nothing changes. The update is visible one cycle after the event.
- R3: Category codes are 0 for uncorrectable, 1 for correctable and 2 for other. An event touches only its own category's status register. The usual pairs are 12/44 for poisoned data, 17/49 for receiver overflow, 18/50 for malformed packets and 20/52 for unsupported requests.
- R4: Register addresses are 0, 2 and 4 for the status registers of categories 0, 1 and 2, and a write there clears the bits that are 1 in the data. Addresses 1, 3 and 5 are their set aliases: a write sets the bits that are 1 in the data, and a read returns the status.
- R5: Header word 1 (address 9) holds header bytes 0 to 7, with byte 0 in bits 63:56. The input header carries byte 0 in bits 127:120.
- R6: Header word 2 (address 10) holds bytes 8 to 11 in bits 63:32. Bits 31:0 hold bytes 12 to 15 only when the format field (byte 0 bits 6:5) is 1 or 3, and zero otherwise.
- R7: Reset zeroes all status, enable and header registers.
- R8: When an event sets a bit that a clearing write removes in the same cycle, the bit ends set. Other bits in the clearing mask are still cleared.
- R9: An event with category code 3 changes no register.
- R10: The header is captured only by an uncorrectable event that has its header flag set and sets a primary bit while no primary bit (31:0) of that register is set. Later events leave the header words unchanged.
- R11: Addresses 6, 7 and 8 are the read/write enable registers of categories 0, 1 and 2. A read returns data with rd_valid one cycle after reg_rd. evt_ready is 0 in reset and 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on or warm reset |
| evt_valid | input | 1 | Error event present |
| evt_ready | output | 1 | Event accepted (high outside reset) |
| evt_cat | input | 2 | Event category code |
| evt_idx | input | 5 | Primary bit index |
| evt_has_hdr | input | 1 | Event carries a receive header |
| evt_hdr | input | 128 | Header, byte 0 in bits 127:120 |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 64 | Write data or mask |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 64 | Read data |

## Verification
A wrong primary/secondary decision shows up in the status read on the next read after the event. It appears either as the wrong bit of the pair, or as a third repeat that alters the register. A broken enable gate or category decode sets a bit in a register that should stay zero, and the next read of that register shows it. A capture condition that fires too often overwrites the header words, so a later read of addresses 9 and 10 returns the later header rather than the first one. A lost set-versus-clear priority makes the bit read back as zero in the cycle after the combined write and event.

// File: rtl/errlog_pkg.sv
package errlog_pkg;
  localparam int NCAT   = 3;
  localparam int ADDR_W = 4;

  typedef enum logic [1:0] {
    CAT_UNCORR = 2'd0,
    CAT_CORR   = 2'd1,
    CAT_OTHER  = 2'd2,
    CAT_NONE   = 2'd3
  } err_cat_e;

  // enable registers follow the status/alias pairs
  localparam logic [ADDR_W-1:0] ADR_EN_BASE = 4'd6;
  localparam logic [ADDR_W-1:0] ADR_HDR_HI  = 4'd9;
  localparam logic [ADDR_W-1:0] ADR_HDR_LO  = 4'd10;
endpackage

// File: rtl/errlog_bank.sv
module errlog_bank #(
  parameter int W = 64
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         ev_hit,
  input  logic [$clog2(W/2)-1:0]       ev_idx,
  input  logic [W-1:0]                 clr_mask,
  input  logic [W-1:0]                 set_mask,
  input  logic                         en_we,
  input  logic [W-1:0]                 en_wdata,
  output logic [W-1:0]                 status,
  output logic [W-1:0]                 enable,
  output logic                         first_log
);
  localparam int HALF  = W / 2;
  localparam int IDX_W = $clog2(HALF);

  logic [IDX_W:0] sec_pos;
  logic [W-1:0]   hw_set;

  assign sec_pos = {1'b0, ev_idx} + (IDX_W+1)'(HALF);

  always_comb begin
    hw_set = '0;
    if (ev_hit && enable[ev_idx]) begin
      if (!status[ev_idx])       hw_set[ev_idx]  = 1'b1;
      else if (!status[sec_pos]) hw_set[sec_pos] = 1'b1;
    end
  end

  // a primary gets logged into a register with no primary yet
  assign first_log = (|hw_set[HALF-1:0]) && !(|status[HALF-1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= '0;
      enable <= '0;
    end else begin
      // hardware set is applied last so it beats a same-cycle clear
      status <= (status & ~clr_mask) | set_mask | hw_set;
      if (en_we) enable <= en_wdata;
    end
  end
endmodule

// File: rtl/errlog_hdr.sv
module errlog_hdr #(
  parameter int W = 64
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cap,
  input  logic [2*W-1:0] hdr,
  output logic [W-1:0]   log_hi,
  output logic [W-1:0]   log_lo
);
  localparam int HW = 2 * W;

  logic four_dw;
  // format field sits in bits 6:5 of byte 0; odd values mean a 4-dword header
  assign four_dw = hdr[HW-3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      log_hi <= '0;
      log_lo <= '0;
    end else if (cap) begin
      log_hi <= hdr[HW-1 -: W];
      log_lo <= {hdr[W-1 -: W/2], four_dw ? hdr[W/2-1:0] : {(W/2){1'b0}}};
    end
  end
endmodule

// File: rtl/errlog_access.sv
module errlog_access
  import errlog_pkg::*;
#(
  parameter int W = 64
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      reg_wr,
  input  logic                      reg_rd,
  input  logic [ADDR_W-1:0]         reg_addr,
  input  logic [W-1:0]              reg_wdata,
  input  logic [NCAT-1:0][W-1:0]    stat_all,
  input  logic [NCAT-1:0][W-1:0]    en_all,
  input  logic [W-1:0]              hdr_hi,
  input  logic [W-1:0]              hdr_lo,
  output logic [NCAT-1:0][W-1:0]    clr_all,
  output logic [NCAT-1:0][W-1:0]    set_all,
  output logic [NCAT-1:0]           en_we,
  output logic                      rd_valid,
  output logic [W-1:0]              rd_data
);
  for (genvar c = 0; c < NCAT; c++) begin : g_dec
    assign clr_all[c] = (reg_wr && reg_addr == ADDR_W'(2*c))   ? reg_wdata : '0;
    assign set_all[c] = (reg_wr && reg_addr == ADDR_W'(2*c+1)) ? reg_wdata : '0;
    assign en_we[c]   = reg_wr && (reg_addr == ADR_EN_BASE + ADDR_W'(c));
  end

  logic [W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    for (int c = 0; c < NCAT; c++) begin
      if (reg_addr == ADDR_W'(2*c) || reg_addr == ADDR_W'(2*c+1)) rd_mux = stat_all[c];
      if (reg_addr == ADR_EN_BASE + ADDR_W'(c))                   rd_mux = en_all[c];
    end
    if (reg_addr == ADR_HDR_HI) rd_mux = hdr_hi;
    if (reg_addr == ADR_HDR_LO) rd_mux = hdr_lo;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= reg_rd;
      if (reg_rd) rd_data <= rd_mux;
    end
  end
endmodule

// File: rtl/errlog_top.sv
module errlog_top
  import errlog_pkg::*;
#(
  parameter int W = 64
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     evt_valid,
  output logic                     evt_ready,
  input  logic [1:0]               evt_cat,
  input  logic [$clog2(W/2)-1:0]   evt_idx,
  input  logic                     evt_has_hdr,
  input  logic [2*W-1:0]           evt_hdr,
  input  logic                     reg_wr,
  input  logic                     reg_rd,
  input  logic [ADDR_W-1:0]        reg_addr,
  input  logic [W-1:0]             reg_wdata,
  output logic                     rd_valid,
  output logic [W-1:0]             rd_data
);
  localparam logic [NCAT-1:0] HDR_CAT_MASK = NCAT'(1) << CAT_UNCORR;

  logic [NCAT-1:0][W-1:0] stat_all, en_all, clr_all, set_all;
  logic [NCAT-1:0]        en_we, first_log, hit;
  logic [W-1:0]           hdr_hi, hdr_lo;
  logic                   cap;

  assign evt_ready = rst_n;

  for (genvar c = 0; c < NCAT; c++) begin : g_bank
    assign hit[c] = evt_valid && evt_ready && (evt_cat == 2'(c));
    errlog_bank #(.W(W)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .ev_hit   (hit[c]),
      .ev_idx   (evt_idx),
      .clr_mask (clr_all[c]),
      .set_mask (set_all[c]),
      .en_we    (en_we[c]),
      .en_wdata (reg_wdata),
      .status   (stat_all[c]),
      .enable   (en_all[c]),
      .first_log(first_log[c])
    );
  end

  assign cap = evt_has_hdr && |(first_log & HDR_CAT_MASK);

  errlog_hdr #(.W(W)) u_hdr (
    .clk   (clk),
    .rst_n (rst_n),
    .cap   (cap),
    .hdr   (evt_hdr),
    .log_hi(hdr_hi),
    .log_lo(hdr_lo)
  );

  errlog_access #(.W(W)) u_acc (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_wr   (reg_wr),
    .reg_rd   (reg_rd),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .stat_all (stat_all),
    .en_all   (en_all),
    .hdr_hi   (hdr_hi),
    .hdr_lo   (hdr_lo),
    .clr_all  (clr_all),
    .set_all  (set_all),
    .en_we    (en_we),
    .rd_valid (rd_valid),
    .rd_data  (rd_data)
  );
endmodule

// File: rtl/errlog_chk.sv
module errlog_chk
  import errlog_pkg::*;
#(
  parameter int W = 64
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   evt_valid,
  input logic [1:0]             evt_cat,
  input logic [$clog2(W/2)-1:0] evt_idx,
  input logic                   reg_wr,
  input logic [NCAT-1:0][W-1:0] stat_all,
  input logic [NCAT-1:0][W-1:0] en_all
);
  localparam int IDX_W = $clog2(W/2);

  for (genvar c = 0; c < NCAT; c++) begin : g_c
    logic sel;
    logic [IDX_W:0] sec;
    assign sel = evt_valid && evt_cat == 2'(c);
    assign sec = {1'b1, evt_idx};

    // R1
    gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sel && !en_all[c][evt_idx] && !reg_wr |=> $stable(stat_all[c]));
    // R2
    primary_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sel && en_all[c][evt_idx] && !stat_all[c][evt_idx] |=> stat_all[c][$past(evt_idx)]);
    // R2
    secondary_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sel && en_all[c][evt_idx] && stat_all[c][evt_idx] && !stat_all[c][sec]
      |=> stat_all[c][$past(sec)]);
    // R2
    both_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sel && stat_all[c][evt_idx] && stat_all[c][sec] && !reg_wr |=> $stable(stat_all[c]));
  end

  // R9
  undef_cat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid && evt_cat == CAT_NONE && !reg_wr |=> $stable(stat_all));
  // R7
  reset_zero_chk: assert property (@(posedge clk)
    !rst_n |=> (stat_all == '0) && (en_all == '0));
endmodule

bind errlog_top errlog_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .evt_valid(evt_valid),
  .evt_cat  (evt_cat),
  .evt_idx  (evt_idx),
  .reg_wr   (reg_wr),
  .stat_all (stat_all),
  .en_all   (en_all)
);

// File: tb/tb_errlog_top.sv
module tb_errlog_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         evt_valid = 1'b0, evt_has_hdr = 1'b0;
  logic         evt_ready;
  logic [1:0]   evt_cat = '0;
  logic [4:0]   evt_idx = '0;
  logic [127:0] evt_hdr = '0;
  logic         reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0]   reg_addr = '0;
  logic [63:0]  reg_wdata = '0;
  logic         rd_valid;
  logic [63:0]  rd_data;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [63:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  errlog_top dut (.*);

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // driver: one cycle with optional event and optional write
  task automatic step(bit ev, logic [1:0] cat, int idx, bit hh, logic [127:0] h,
                      bit wr, logic [3:0] a, logic [63:0] d);
    @(negedge clk);
    evt_valid = ev; evt_cat = cat; evt_idx = 5'(idx); evt_has_hdr = hh; evt_hdr = h;
    reg_wr = wr; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    evt_valid = 0; evt_has_hdr = 0; reg_wr = 0;
  endtask

  task automatic ev(logic [1:0] cat, int idx, bit hh, logic [127:0] h);
    step(1, cat, idx, hh, h, 0, 4'd0, 64'd0);
  endtask

  task automatic wr(logic [3:0] a, logic [63:0] d);
    step(0, 2'd0, 0, 0, 128'd0, 1, a, d);
  endtask

  // read request: expected value queued for the monitor
  task automatic rd(logic [3:0] a, logic [63:0] exp, string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    reg_rd = 1; reg_addr = a;
    @(negedge clk);
    reg_rd = 0;
  endtask

  // monitor
  always @(negedge clk) begin
    if (rd_valid) begin
      if (exp_q.size() == 0) begin
        checks++; failures++;
        $display("FAIL R11 unexpected rd_valid act=%h exp=none", rd_data);
      end else begin
        logic [63:0] e;
        string t;
        e = exp_q.pop_front(); t = tag_q.pop_front();
        chk(t, rd_data, e);
      end
    end
  end

  localparam logic [127:0] HDR_A = 128'h6000_0001_0000_000F_1122_3344_5566_7788;
  localparam logic [127:0] HDR_B = 128'h7F00_0003_DEAD_BEEF_0102_0304_0506_0708;
  localparam logic [127:0] HDR_C = 128'h4000_0002_AAAA_BBBB_CCCC_DDDD_EEEE_FFFF;
  localparam logic [63:0]  B = 64'd1;

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 ready low in reset", 64'(evt_ready), 64'd0);
    rst_n = 1;
    @(negedge clk);
    chk("R11 ready high", 64'(evt_ready), 64'd1);
    rd(4'd0, 0, "R7 UE status reset");
    rd(4'd2, 0, "R7 CE status reset");
    rd(4'd4, 0, "R7 OE status reset");
    rd(4'd9, 0, "R7 hdr1 reset");
    rd(4'd10, 0, "R7 hdr2 reset");

    ev(2'd0, 12, 1, HDR_B);
    rd(4'd0, 0, "R1 disabled event ignored");
    rd(4'd9, 0, "R10 no capture when disabled");

    wr(4'd6, (B<<12)|(B<<17)|(B<<18)|(B<<20));
    rd(4'd6, (B<<12)|(B<<17)|(B<<18)|(B<<20), "R11 enable readback");

    ev(2'd0, 12, 1, HDR_A);
    rd(4'd0, B<<12, "R2 primary set");
    rd(4'd9, 64'h6000_0001_0000_000F, "R5 hdr1 packing");
    rd(4'd10, 64'h1122_3344_5566_7788, "R6 hdr2 four-dword");

    ev(2'd0, 12, 1, HDR_B);
    rd(4'd1, (B<<12)|(B<<44), "R2 secondary set, R4 alias read");
    rd(4'd9, 64'h6000_0001_0000_000F, "R10 hdr1 kept");
    ev(2'd0, 12, 0, 128'd0);
    rd(4'd0, (B<<12)|(B<<44), "R2 third repeat lost");

    wr(4'd0, B<<12);
    rd(4'd0, B<<44, "R4 write-one-to-clear");

    ev(2'd0, 18, 1, HDR_C);
    rd(4'd0, (B<<44)|(B<<18), "R3 malformed pair primary");
    rd(4'd9, 64'h4000_0002_AAAA_BBBB, "R10 recapture after clear");
    rd(4'd10, 64'hCCCC_DDDD_0000_0000, "R6 hdr2 three-dword zero fill");

    wr(4'd1, B<<3);
    rd(4'd0, (B<<44)|(B<<18)|(B<<3), "R4 write-one-to-set");

    ev(2'd3, 12, 1, HDR_A);
    rd(4'd0, (B<<44)|(B<<18)|(B<<3), "R9 undefined category UE");
    rd(4'd2, 0, "R9 undefined category CE");
    rd(4'd4, 0, "R9 undefined category OE");
    rd(4'd9, 64'h4000_0002_AAAA_BBBB, "R9 header untouched");

    wr(4'd7, B<<5);
    ev(2'd1, 5, 0, 128'd0);
    ev(2'd2, 5, 0, 128'd0);
    rd(4'd2, B<<5, "R3 correctable category");
    rd(4'd4, 0, "R3 other category untouched");
    rd(4'd0, (B<<44)|(B<<18)|(B<<3), "R3 uncorrectable untouched");

    step(1, 2'd0, 20, 0, 128'd0, 1, 4'd0, (B<<20)|(B<<18));
    rd(4'd0, (B<<44)|(B<<20)|(B<<3), "R8 set beats clear");

    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    rd(4'd0, 0, "R7 warm reset UE");
    rd(4'd2, 0, "R7 warm reset CE");
    rd(4'd6, 0, "R7 warm reset enable");
    rd(4'd10, 0, "R7 warm reset hdr2");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      checks++; failures++;
      $display("FAIL R11 missing read data act=%0d exp=0 pending", exp_q.size());
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule